// File: doc/BRIEF.md
# Fixed-Point Lifting Step Unit

This block evaluates one lifting step of a fixed-point filter on 32-bit two's-complement data: g = (((a + b) * c + d) >> e) + f. It first sums a and b, multiplies the sum by c into a full 64-bit signed product, and adds the rounding term d = 2^(e-1) when rounding is requested. It then shifts right arithmetically by the run-time amount e and adds the post-offset f. Only a 32-bit result is written back. Product bits above the selected window are dropped.

In the common 4:28 format (4 integer bits, 28 fraction bits), a shift of 28 returns product bits [59:28] in 4:28 form. A bypass control zeroes both b and f, which leaves a plain multiply, round and shift. The datapath has five register stages and a single advance signal. A new operation can enter on every cycle while the downstream side is ready. When the downstream side is not ready, every stage freezes and nothing new is taken.

Top module: `lift_step_unit`

## Requirements
- R1: An operation accepted at a clock edge appears on `out_data` with `out_valid` high exactly 5 advancing edges later, and results leave in issue order.
- R2: The result equals the low 32 bits of ((sext(s) * sext(c) + d) >>> e) + f, where s is the sum of a and b and the product and round sum are kept without loss.
- R3: The full 64-bit signed product is retained before the shift, so e = 32 yields the upper product word.
- R4: When `in_round` is 1 and e > 0, d = 2^(e-1). When `in_round` is 0 or e = 0, d = 0.
- R5: With `in_bypass` = 1, `in_b` and `in_f` have no effect, as if both were zero.
- R6: The sum a + b wraps to 32 bits before the multiply.
- R7: The addition of f wraps modulo 2^32 with no saturation.
- R8: `in_ready` equals `out_ready`, and while it is high one operation per cycle is accepted back to back.
- R9: While `out_ready` is 0, no operation is accepted, and `out_valid` and `out_data` hold their values.
- R10: While `rst` is high (synchronous, active high), `out_valid` is 0 from the next edge on.
- R11: The shift is arithmetic over the round sum. For example, e = 63 on a negative round sum gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Operand set is taken at the next edge when in_valid is high |
| in_a | input | 32 | Pre-add operand a |
| in_b | input | 32 | Pre-add operand b |
| in_c | input | 32 | Multiplier c |
| in_f | input | 32 | Post-offset f |
| in_shift | input | 6 | Right-shift amount e, 0 to 63 |
| in_round | input | 1 | Enable the half-LSB rounding term |
| in_bypass | input | 1 | Zero b and f |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream can take a result; advances the pipeline |
| out_data | output | 32 | Result g |

## Verification
Each result is due on the fifth rising edge after its acceptance, counting only edges at which `out_ready` was high. The bench keeps a five-slot reference delay line that shifts on exactly those edges. It compares `out_valid` and `out_data` against the last slot at every falling edge, so a result that arrives one cycle early or late shows up as a mismatch. Stall cycles leave the reference line untouched, which checks both that outputs hold and that nothing is taken while `in_ready` is low.

// File: rtl/lift_pkg.sv
package lift_pkg;
    localparam int DATA_W  = 32;
    localparam int PROD_W  = 2 * DATA_W;
    localparam int SHIFT_W = $clog2(PROD_W);

    // sideband carried alongside the arithmetic through the stages
    typedef struct packed {
        logic               vld;
        logic [SHIFT_W-1:0] sh;
        logic [DATA_W-1:0]  post;
    } side_t;
endpackage

// File: rtl/lift_preadd.sv
module lift_preadd
    import lift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic [DATA_W-1:0]  in_c,
    input  logic [DATA_W-1:0]  in_f,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_round,
    input  logic               in_bypass,
    output side_t              s1_side,
    output logic               s1_rnd,
    output logic [DATA_W-1:0]  s1_sum,
    output logic [DATA_W-1:0]  s1_mul
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] f_eff;

    always_comb begin
        b_eff = in_bypass ? '0 : in_b;
        f_eff = in_bypass ? '0 : in_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_side <= '0;
            s1_rnd  <= 1'b0;
            s1_sum  <= '0;
            s1_mul  <= '0;
        end else if (adv) begin
            s1_side.vld  <= in_valid;
            s1_side.sh   <= in_shift;
            s1_side.post <= f_eff;
            s1_rnd       <= in_round && (in_shift != '0);
            s1_sum       <= in_a + b_eff;   // wraps to DATA_W bits
            s1_mul       <= in_c;
        end
    end

    // R5: bypass removes b and f at the first stage
    p_bypass_zero_r5: assert property (@(posedge clk) disable iff (rst)
        adv && in_valid && in_bypass |=> s1_side.post == '0 && s1_sum == $past(in_a));

    // R9: a frozen pipeline keeps its first stage
    p_stage1_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(s1_side) && $stable(s1_sum) && $stable(s1_mul));
endmodule

// File: rtl/lift_mul_round.sv
module lift_mul_round
    import lift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  side_t             s1_side,
    input  logic              s1_rnd,
    input  logic [DATA_W-1:0] s1_sum,
    input  logic [DATA_W-1:0] s1_mul,
    output side_t             s3_side,
    output logic [PROD_W:0]   s3_rsum
);
    side_t                     s2_side;
    logic                      s2_rnd;
    logic signed [PROD_W-1:0]  s2_prod;
    logic [PROD_W:0]           half;
    logic [PROD_W:0]           prod_ext;

    always_comb begin
        prod_ext = {s2_prod[PROD_W-1], s2_prod};
        half     = '0;
        if (s2_rnd)
            half = {{PROD_W{1'b0}}, 1'b1} << (s2_side.sh - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_side <= '0;
            s2_rnd  <= 1'b0;
            s2_prod <= '0;
            s3_side <= '0;
            s3_rsum <= '0;
        end else if (adv) begin
            s2_side <= s1_side;
            s2_rnd  <= s1_rnd;
            s2_prod <= $signed({{DATA_W{s1_sum[DATA_W-1]}}, s1_sum})
                     * $signed({{DATA_W{s1_mul[DATA_W-1]}}, s1_mul});
            s3_side <= s2_side;
            s3_rsum <= prod_ext + half;   // one guard bit, never overflows
        end
    end

    // R1: a valid operation moves one stage per advancing edge
    p_advance_r1: assert property (@(posedge clk) disable iff (rst)
        adv && s1_side.vld |=> s2_side.vld);

    // R4: without rounding the round sum is the bare sign-extended product
    p_no_round_r4: assert property (@(posedge clk) disable iff (rst)
        adv && s2_side.vld && !s2_rnd |=> s3_rsum == $past(prod_ext));

    // R9: frozen middle stages
    p_mid_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(s3_rsum) && $stable(s3_side));
endmodule

// File: rtl/lift_shift_post.sv
module lift_shift_post
    import lift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  side_t             s3_side,
    input  logic [PROD_W:0]   s3_rsum,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic signed [PROD_W:0] shifted;
    logic [DATA_W-1:0]      s4_val;
    logic [DATA_W-1:0]      s4_post;
    logic                   s4_vld;

    always_comb begin
        shifted = $signed(s3_rsum) >>> s3_side.sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s4_val    <= '0;
            s4_post   <= '0;
            s4_vld    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (adv) begin
            s4_val    <= shifted[DATA_W-1:0];
            s4_post   <= s3_side.post;
            s4_vld    <= s3_side.vld;
            out_valid <= s4_vld;
            out_data  <= s4_val + s4_post;   // wraps modulo 2^DATA_W
        end
    end

    // R11: full-width arithmetic shift of a negative sum leaves all ones
    p_sign_fill_r11: assert property (@(posedge clk) disable iff (rst)
        adv && s3_side.vld && s3_rsum[PROD_W] && s3_side.sh == SHIFT_W'(PROD_W - 1)
        |=> s4_val == '1);

    // R9: output holds while downstream is not ready
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !adv |=> out_valid && $stable(out_data));

    // R1: last internal stage feeds the output on the next advance
    p_out_advance_r1: assert property (@(posedge clk) disable iff (rst)
        adv && s4_vld |=> out_valid);
endmodule

// File: rtl/lift_step_unit.sv
module lift_step_unit
    import lift_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic [DATA_W-1:0]  in_c,
    input  logic [DATA_W-1:0]  in_f,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_round,
    input  logic               in_bypass,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data
);
    logic              adv;
    side_t             s1_side;
    logic              s1_rnd;
    logic [DATA_W-1:0] s1_sum;
    logic [DATA_W-1:0] s1_mul;
    side_t             s3_side;
    logic [PROD_W:0]   s3_rsum;

    assign adv      = out_ready;
    assign in_ready = adv;

    lift_preadd u_preadd (
        .clk(clk), .rst(rst), .adv(adv), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_f(in_f),
        .in_shift(in_shift), .in_round(in_round), .in_bypass(in_bypass),
        .s1_side(s1_side), .s1_rnd(s1_rnd), .s1_sum(s1_sum), .s1_mul(s1_mul)
    );

    lift_mul_round u_mul (
        .clk(clk), .rst(rst), .adv(adv),
        .s1_side(s1_side), .s1_rnd(s1_rnd), .s1_sum(s1_sum), .s1_mul(s1_mul),
        .s3_side(s3_side), .s3_rsum(s3_rsum)
    );

    lift_shift_post u_post (
        .clk(clk), .rst(rst), .adv(adv),
        .s3_side(s3_side), .s3_rsum(s3_rsum),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R10: reset clears the result flag
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/lift_step_unit_tb_top.sv
`timescale 1ns/1ps
module lift_step_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0, in_b = '0, in_c = '0, in_f = '0;
    logic [5:0]  in_shift = '0;
    logic        in_round = 1'b0, in_bypass = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1";
    logic [31:0] seed = 32'h1234_5678;

    // reference delay line, one slot per stage
    bit          ev [5];
    logic [31:0] ed [5];
    string       et [5];

    always #4 clk = ~clk;

    lift_step_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_f(in_f),
        .in_shift(in_shift), .in_round(in_round), .in_bypass(in_bypass),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] ref_step(logic [31:0] a, logic [31:0] b,
            logic [31:0] c, logic [31:0] f, logic [5:0] e, logic rnd, logic byp);
        logic [31:0]         s;
        logic signed [127:0] x, y, p;
        s = a + (byp ? 32'd0 : b);
        x = {{96{s[31]}}, s};
        y = {{96{c[31]}}, c};
        p = x * y;
        if (rnd && e != 0) p = p + (128'sd1 <<< (e - 1));
        p = p >>> e;
        return p[31:0] + (byp ? 32'd0 : f);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 5; i++) begin ev[i] = 1'b0; ed[i] = '0; et[i] = ""; end
        end else if (out_ready) begin
            for (int i = 4; i > 0; i--) begin ev[i] = ev[i-1]; ed[i] = ed[i-1]; et[i] = et[i-1]; end
            ev[0] = in_valid;
            ed[0] = ref_step(in_a, in_b, in_c, in_f, in_shift, in_round, in_bypass);
            et[0] = cur_tag;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R10", {31'd0, out_valid}, 32'd0);
            end else begin
                check({et[4], " valid"}, {31'd0, out_valid}, {31'd0, ev[4]});
                if (ev[4]) check(et[4], out_data, ed[4]);
                check("R8", {31'd0, in_ready}, {31'd0, out_ready});
            end
        end
    end

    task automatic drive(bit v, logic [31:0] a, logic [31:0] b, logic [31:0] c,
            logic [31:0] f, logic [5:0] e, bit rnd, bit byp, bit rdy, string tag);
        @(posedge clk); #1;
        in_valid = v; in_a = a; in_b = b; in_c = c; in_f = f;
        in_shift = e; in_round = rnd; in_bypass = byp; out_ready = rdy; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 1, cur_tag);
    endtask

    function automatic logic [31:0] nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: single isolated operation, latency checked against delay line
        drive(1, 32'h0000_0003, 32'h0000_0004, 32'h0000_0005, 32'h0000_0001, 0, 0, 0, 1, "R1");
        idle(7);
        // R2: 4:28 data, 1.5+0.25 times 2.0 with rounding
        drive(1, 32'h1800_0000, 32'h0400_0000, 32'h2000_0000, 32'h0100_0000, 28, 1, 0, 1, "R2");
        drive(1, 32'hF000_0000, 32'h0123_4567, 32'h0987_6543, 32'h0000_0011, 28, 0, 0, 1, "R2");
        // R3: upper product word
        drive(1, 32'h1234_5678, 32'h0, 32'h0FED_CBA9, 32'h0, 32, 0, 0, 1, "R3");
        drive(1, 32'h8765_4321, 32'h0, 32'h7FFF_FFFF, 32'h0, 32, 0, 0, 1, "R3");
        // R4: rounding corner cases
        drive(1, 32'd3, 32'd0, 32'd1, 32'd0, 1, 1, 0, 1, "R4");
        drive(1, 32'd3, 32'd0, 32'd1, 32'd0, 1, 0, 0, 1, "R4");
        drive(1, 32'd7, 32'd0, 32'd1, 32'd0, 0, 1, 0, 1, "R4");
        drive(1, 32'hFFFF_FFFD, 32'd0, 32'd1, 32'd0, 1, 1, 0, 1, "R4");
        // R5: bypass ignores b and f
        drive(1, 32'd10, 32'd123, 32'd7, 32'd456, 0, 0, 1, 1, "R5");
        drive(1, 32'h1000_0000, 32'h7777_7777, 32'h1000_0000, 32'hFFFF_0000, 28, 1, 1, 1, "R5");
        // R6: pre-add wraps
        drive(1, 32'h7FFF_FFFF, 32'd1, 32'd1, 32'd0, 0, 0, 0, 1, "R6");
        // R7: post-add wraps
        drive(1, 32'd1, 32'd0, 32'd1, 32'h7FFF_FFFF, 0, 0, 0, 1, "R7");
        drive(1, 32'd5, 32'd0, 32'd1, 32'hFFFF_FFFF, 0, 0, 0, 1, "R7");
        // R11: most negative operands and extreme shifts
        drive(1, 32'h8000_0000, 32'd0, 32'h8000_0000, 32'd0, 63, 0, 0, 1, "R11");
        drive(1, 32'h8000_0000, 32'd0, 32'h8000_0000, 32'd0, 63, 1, 0, 1, "R11");
        drive(1, 32'h8000_0000, 32'd0, 32'd1, 32'd0, 63, 0, 0, 1, "R11");
        drive(1, 32'h8000_0000, 32'd0, 32'h8000_0000, 32'd0, 28, 1, 0, 1, "R11");
        drive(1, 32'h8000_0000, 32'd0, 32'h7FFF_FFFF, 32'd0, 0, 1, 0, 1, "R11");
        idle(7);
        // R8: back-to-back stream
        for (int i = 0; i < 40; i++)
            drive(1, nxt(), nxt(), nxt(), nxt(), 6'(nxt()), nxt() % 2 == 1, nxt() % 4 == 0, 1, "R8");
        idle(7);
        // R9: stalls interleaved with traffic
        for (int i = 0; i < 80; i++) begin
            logic [31:0] r;
            r = nxt();
            drive(r[3], nxt(), nxt(), nxt(), nxt(), 6'(nxt()), r[5], r[6] & r[7], r[9] | r[10], "R9");
        end
        idle(8);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule